// File: doc/BRIEF.md
# Hardware Thread Context Switch Scheduler

This block decides which of eight hardware thread contexts owns a single-issue packet engine. Each context keeps a ready bit. The bit is cleared by a one-cycle block pulse from that context, for example when it waits on memory. A wake pulse sets it again. The running context keeps the engine until its own ready bit drops. The scheduler then searches the other contexts in round-robin order, starting with the one after the current context. It hands the engine to the first ready context it finds. Every switch drains the pipeline, so issue stays off for a fixed number of flush cycles, and the switch is announced by a one-cycle flush pulse.

When no context is ready, the engine enters an idle stall. Issue stays off and the last active context ID is held. As soon as any context becomes ready, the same round-robin order picks one, counted from the last active context, which itself comes last. If the pick is that same context, issue resumes without a flush. Otherwise the normal switch penalty applies.

The controller has three named states. RUN issues from the active context. FLUSH is the switch penalty. IDLE means no context is ready. The transitions are:
- RUN→FLUSH: stall, and another context is ready.
- RUN→IDLE: stall, and none is ready.
- FLUSH→RUN: the penalty has expired.
- IDLE→FLUSH: a different context wakes.
- IDLE→RUN: the same context wakes.

Top module: `ctx_switch_sched`

## Requirements
- R1: After reset, context 0 is active, all eight ready bits are set, issue_en_o is 1 and flush_o is 0.
- R2: A block pulse on a context clears its ready bit and a wake pulse sets it. When both arrive in the same cycle, the wake wins. Pulses on contexts other than the active one leave active_ctx_o and issue_en_o unchanged.
- R3: In the cycle after the active context's block pulse, issue_en_o is 0. This is the decision cycle, and active_ctx_o still shows the stalled context.
- R4: On a stall, the new context is the first ready one in the order current+1, current+2, … modulo 8, wrapping past context 7 to context 0.
- R5: On a switch, flush_o is 1 for exactly one cycle: the cycle after the decision cycle. In that cycle active_ctx_o already shows the new ID, which differs from the previous one.
- R6: issue_en_o stays 0 for FLUSH_CYCLES (default 3) cycles, starting with the flush_o cycle. It returns to 1 in the following cycle if the new context is still ready.
- R7: When no context is ready at the decision cycle, the engine enters IDLE. issue_en_o and flush_o stay 0 and active_ctx_o holds the last active ID for as long as no context is ready.
- R8: Leaving IDLE, the first ready context in the order last+1, …, last (the last active context considered last) is chosen. If it differs from the last active context, a flush and the R6 penalty follow. If it is the same context, issue_en_o returns to 1 in the cycle after the decision cycle with no flush pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_i | input | 8 | Per-context wake pulses (bit n = context n) |
| block_i | input | 8 | Per-context block pulses (bit n = context n) |
| active_ctx_o | output | 3 | ID of the context owning the engine |
| issue_en_o | output | 1 | High when the active context may issue |
| flush_o | output | 1 | One-cycle pulse marking a context switch |

## Verification
A corrupted ready bit shows up at the ports on the next stall of the active context. The switch then lands on the wrong ID, or the engine idles while a context is ready, and the error is visible in the flush cycle two clocks after the block pulse. A wrong search base or wrong wrap logic shows the same way, as a wrong active_ctx_o in the flush cycle. A penalty counter that is off by one moves the rising edge of issue_en_o by a cycle, so the bench checks every cycle of the flush window and the first issuing cycle after it.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;

    // Controller states of the context scheduler
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,   // active context issues
        ST_FLUSH = 2'd1,   // switch penalty, pipeline drained
        ST_IDLE  = 2'd2    // no context ready, engine stalled
    } sched_state_e;

endpackage

// File: rtl/ctx_ready_track.sv
module ctx_ready_track #(
    parameter int NUM_CTX = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTX-1:0] wake_i,
    input  logic [NUM_CTX-1:0] block_i,
    output logic [NUM_CTX-1:0] rdy_o
);

    logic [NUM_CTX-1:0] rdy_q;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdy_q[g] <= 1'b1;
            end else if (wake_i[g]) begin
                rdy_q[g] <= 1'b1;          // wake has priority over block
            end else if (block_i[g]) begin
                rdy_q[g] <= 1'b0;
            end
        end

        // R2: a wake always leaves the context ready
        p_wake_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
            wake_i[g] |=> rdy_q[g]);

        // R2: a lone block clears readiness
        p_block_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (block_i[g] && !wake_i[g]) |=> !rdy_q[g]);
    end

    assign rdy_o = rdy_q;

endmodule

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
    parameter int NUM_CTX = 8,
    localparam int IDW    = $clog2(NUM_CTX)
) (
    input  logic [NUM_CTX-1:0] req_i,
    input  logic [IDW-1:0]     base_i,
    output logic               found_o,
    output logic [IDW-1:0]     pick_o
);

    // Context count must be a power of two so the wrap is a plain truncation
    initial begin
        if (NUM_CTX != (1 << IDW)) $error("NUM_CTX must be a power of two");
    end

    logic [IDW:0]   sum;
    logic [IDW-1:0] idx;

    // Walk offsets from farthest to nearest so the nearest ready context
    // (base+1 first, base itself last) is the one left in pick_o.
    always_comb begin
        pick_o = '0;
        sum    = '0;
        idx    = '0;
        for (int off = NUM_CTX; off >= 1; off--) begin
            sum = {1'b0, base_i} + (IDW+1)'(off);
            idx = sum[IDW-1:0];
            if (req_i[idx]) pick_o = idx;
        end
    end

    assign found_o = |req_i;

endmodule

// File: rtl/ctx_flush_timer.sv
module ctx_flush_timer #(
    parameter int FLUSH_CYCLES = 3,
    localparam int CW          = $clog2(FLUSH_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic last_o
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CW'(FLUSH_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);

    // R6: the penalty counter never leaves its programmed window
    p_timer_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(FLUSH_CYCLES - 1));

endmodule

// File: rtl/ctx_switch_sched.sv
module ctx_switch_sched
    import ctx_sched_pkg::*;
#(
    parameter int NUM_CTX      = 8,
    parameter int FLUSH_CYCLES = 3,
    localparam int IDW         = $clog2(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTX-1:0] wake_i,
    input  logic [NUM_CTX-1:0] block_i,
    output logic [IDW-1:0]     active_ctx_o,
    output logic               issue_en_o,
    output logic               flush_o
);

    sched_state_e       state_q, state_d;
    logic [IDW-1:0]     act_q, act_d;
    logic               flush_q, flush_d;
    logic               timer_start;
    logic               timer_last;
    logic [NUM_CTX-1:0] rdy;
    logic               pick_found;
    logic [IDW-1:0]     pick_id;

    ctx_ready_track #(.NUM_CTX(NUM_CTX)) u_ready (
        .clk     (clk),
        .rst_n   (rst_n),
        .wake_i  (wake_i),
        .block_i (block_i),
        .rdy_o   (rdy)
    );

    ctx_rr_pick #(.NUM_CTX(NUM_CTX)) u_pick (
        .req_i   (rdy),
        .base_i  (act_q),
        .found_o (pick_found),
        .pick_o  (pick_id)
    );

    ctx_flush_timer #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (timer_start),
        .last_o  (timer_last)
    );

    // Next-state decision
    always_comb begin
        state_d     = state_q;
        act_d       = act_q;
        flush_d     = 1'b0;
        timer_start = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (!rdy[act_q]) begin
                    if (pick_found) begin
                        state_d     = ST_FLUSH;
                        act_d       = pick_id;
                        flush_d     = 1'b1;
                        timer_start = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_FLUSH: begin
                if (timer_last) state_d = ST_RUN;
            end
            ST_IDLE: begin
                if (pick_found) begin
                    if (pick_id != act_q) begin
                        state_d     = ST_FLUSH;
                        act_d       = pick_id;
                        flush_d     = 1'b1;
                        timer_start = 1'b1;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            act_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
            flush_q <= flush_d;
        end
    end

    // Outputs
    always_comb begin
        active_ctx_o = act_q;
        flush_o      = flush_q;
        issue_en_o   = (state_q == ST_RUN) && rdy[act_q];
    end

    // R5: every flush pulse announces a different context
    p_flush_new_ctx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (active_ctx_o != $past(active_ctx_o)));

    // R5: the flush pulse lasts one cycle
    p_flush_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    // R6: no issue while the pipeline is drained
    p_flush_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> !issue_en_o);

    // R7: the active ID only moves together with a flush pulse
    p_ctx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_o |-> $stable(active_ctx_o));

    // R3: issue only from a context whose ready bit is set
    p_issue_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en_o |-> rdy[active_ctx_o]);

endmodule

// File: tb/ctx_switch_sched_bench.sv
`timescale 1ns/100ps
module ctx_switch_sched_bench;

    localparam int NCTX  = 8;
    localparam int FLUSH = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCTX-1:0] wake_i = '0;
    logic [NCTX-1:0] block_i = '0;
    logic [2:0]      active_ctx_o;
    logic            issue_en_o;
    logic            flush_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ctx_switch_sched #(.NUM_CTX(NCTX), .FLUSH_CYCLES(FLUSH)) u_ctx_switch_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .wake_i       (wake_i),
        .block_i      (block_i),
        .active_ctx_o (active_ctx_o),
        .issue_en_o   (issue_en_o),
        .flush_o      (flush_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse(logic [NCTX-1:0] wk, logic [NCTX-1:0] bk);
        wake_i  = wk;
        block_i = bk;
        tick();
        wake_i  = '0;
        block_i = '0;
    endtask

    // Called in the decision cycle; walks through the flush window
    task automatic expect_switch(string tag, int new_ctx);
        check({tag, " decision issue"}, int'(issue_en_o), 0);
        check({tag, " decision flush"}, int'(flush_o), 0);
        tick();
        check({tag, " R5 flush pulse"}, int'(flush_o), 1);
        check({tag, " R5 new ctx"}, int'(active_ctx_o), new_ctx);
        check({tag, " R6 issue in flush"}, int'(issue_en_o), 0);
        for (int i = 1; i < FLUSH; i++) begin
            tick();
            check({tag, " R5 single pulse"}, int'(flush_o), 0);
            check({tag, " R6 issue held low"}, int'(issue_en_o), 0);
        end
        tick();
        check({tag, " R6 issue resumes"}, int'(issue_en_o), 1);
        check({tag, " R6 ctx kept"}, int'(active_ctx_o), new_ctx);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1 ctx", int'(active_ctx_o), 0);
        check("R1 issue", int'(issue_en_o), 1);
        check("R1 flush", int'(flush_o), 0);
    endtask

    task automatic t_other_pulses();
        pulse('0, 8'h08);
        check("R2 foreign block ctx", int'(active_ctx_o), 0);
        check("R2 foreign block issue", int'(issue_en_o), 1);
        pulse(8'h20, '0);
        check("R2 foreign wake issue", int'(issue_en_o), 1);
    endtask

    task automatic t_first_switch();
        pulse('0, 8'h01);
        check("R3 stall ctx", int'(active_ctx_o), 0);
        expect_switch("R3 stall 0->1", 1);
    endtask

    task automatic t_skip_blocked();
        pulse('0, 8'h04);
        check("R2 block 2 keeps ctx", int'(active_ctx_o), 1);
        pulse('0, 8'h02);
        expect_switch("R4 skip 2,3", 4);
    endtask

    task automatic t_wrap();
        pulse('0, 8'hE0);
        pulse(8'h02, '0);
        pulse('0, 8'h10);
        expect_switch("R4 wrap to 1", 1);
    endtask

    task automatic t_wake_wins();
        pulse(8'h40, 8'h40);
        check("R2 same-cycle ctx", int'(active_ctx_o), 1);
        pulse('0, 8'h02);
        expect_switch("R2 wake wins ctx6", 6);
    endtask

    task automatic t_idle_same();
        pulse('0, 8'h40);
        check("R7 decision issue", int'(issue_en_o), 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R7 idle issue", int'(issue_en_o), 0);
            check("R7 idle flush", int'(flush_o), 0);
            check("R7 idle ctx", int'(active_ctx_o), 6);
        end
        pulse(8'h40, '0);
        check("R8 same decision issue", int'(issue_en_o), 0);
        tick();
        check("R8 same resume issue", int'(issue_en_o), 1);
        check("R8 same no flush", int'(flush_o), 0);
        check("R8 same ctx", int'(active_ctx_o), 6);
    endtask

    task automatic t_idle_other();
        pulse('0, 8'h40);
        tick();
        check("R7 idle again", int'(issue_en_o), 0);
        pulse(8'h84, '0);
        expect_switch("R8 from idle 6->7", 7);
    endtask

    task automatic t_idle_last();
        pulse('0, 8'h84);
        tick();
        tick();
        check("R7 idle both blocked", int'(issue_en_o), 0);
        check("R7 idle ctx", int'(active_ctx_o), 7);
        pulse(8'hA0, '0);
        expect_switch("R8 last ctx considered last", 5);
    endtask

    initial begin
        t_reset();
        t_other_pulses();
        t_first_switch();
        t_skip_blocked();
        t_wrap();
        t_wake_wins();
        t_idle_same();
        t_idle_other();
        t_idle_last();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule